// File: doc/BRIEF.md
# Decode-Stage Hazard Interlock and Operand Bypass Control

This block decides, every cycle, whether the instruction sitting in decode may move on to execute in a five-stage integer pipeline (fetch, decode, execute, memory, writeback). It compares each source register index that decode reads against the destination index of every older instruction still in flight in execute, memory and writeback. When a conflict cannot be covered, it raises a stall. The stall freezes the PC and the fetch/decode register and also turns the execute slot into a bubble. When a conflict can be covered, it chooses, for each ALU operand, where execute should take the value from.

The operand selects are computed from decode-stage information and registered, so they are valid during the cycle in which the instruction executes. A match against execute therefore becomes a select of the execute/memory result register one cycle later. A match against memory becomes a select of the memory/writeback register. A match against writeback becomes a select of a held copy of the last writeback data. That held-copy path is only needed when the register file cannot return a value written in the same cycle.

Two parameters fix the behaviour. `BYPASS` chooses between interlock-only operation and full bypassing. `WB_SAME_CYCLE` states whether a writeback-cycle write is visible to a decode read in that same cycle. The register file, the ALU, the data memory and the bypass multiplexers themselves lie outside this block.

Top module: `hazard_resolver`

## Requirements
- R1: A source whose index is 0 never causes a stall and never gets a select other than register-file (0).
- R2: A source whose use flag is low never causes a stall and never gets a select other than register-file.
- R3: With BYPASS=0, the stall is high in the same cycle whenever a used non-zero source matches the destination of a writing instruction in execute or in memory.
- R4: With BYPASS=0, a match against a writing instruction in writeback stalls only when WB_SAME_CYCLE=0. A dependent instruction directly behind its producer therefore sees 2 stall cycles when WB_SAME_CYCLE=1 and 3 when it is 0.
- R5: With BYPASS=1, a match against a non-load writer in execute gives no stall, and the operand select one cycle later is 1 (execute/memory result register).
- R6: With BYPASS=1, a match against a load in execute stalls for that cycle.
- R7: With BYPASS=1, the closest match being in memory gives, one cycle later, select 2 (memory/writeback register), with no stall.
- R8: With BYPASS=1, the closest match being in writeback gives, one cycle later, select 0 when WB_SAME_CYCLE=1 and select 3 (held writeback data) when WB_SAME_CYCLE=0.
- R9: When several older stages write the matching register, the youngest wins: execute before memory before writeback.
- R10: The bubble output equals the stall output. In the cycle after a stall, every operand select is 0, because the execute slot holds a bubble.
- R11: While reset (active low, synchronous) is asserted, all operand selects are 0 after the next clock edge.
- R12: A stage whose write-enable is low is never a dependency, whatever its destination index.
- R13: With BYPASS=0, every operand select is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_src_idx | input | NSRC*AW | Decode source indices, operand k in bits [k*AW +: AW] |
| dec_src_use | input | NSRC | Operand k is actually read by the decode instruction |
| ex_dst | input | AW | Destination index of the execute-stage instruction |
| ex_wr | input | 1 | Execute-stage instruction writes a register |
| ex_ld | input | 1 | Execute-stage instruction is a load |
| mem_dst | input | AW | Destination index of the memory-stage instruction |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| wb_dst | input | AW | Destination index of the writeback-stage instruction |
| wb_wr | input | 1 | Writeback-stage instruction writes a register |
| stall_o | output | 1 | Hold PC and fetch/decode register |
| bubble_o | output | 1 | Load a bubble into the execute stage |
| fwd_sel_o | output | 2*NSRC | Execute-stage select for operand k in bits [2k +: 2] |

## Verification
On every cycle, the bound checker guards the properties that hold locally: a zero or unused source never stalls, a stall is always followed by all-zero selects, writers with their enables low never stall decode, interlock mode never drives a non-zero select, and a non-load execute match in bypass mode turns into select 1 one cycle later. The bench runs the same stimulus through all four parameter combinations against a model in the bench. That comparison is what shows the whole stall pattern behind a producer, the load-use bubble, the preference of execute over memory over writeback, and the held-writeback select that appears only when same-cycle register reads are not available.

// File: rtl/hzd_pkg.sv
`timescale 1ns/1ps
// Shared types for the hazard resolver.
// Assumes: two-bit select encoding consumed by the execute-stage operand muxes.
package hzd_pkg;

    // Operand source chosen for the execute stage
    typedef enum logic [1:0] {
        FWD_RF  = 2'd0,   // value read from the register file in decode
        FWD_EXM = 2'd1,   // execute/memory pipeline result register
        FWD_MWB = 2'd2,   // memory/writeback pipeline register (ALU or load data)
        FWD_WBH = 2'd3    // held copy of the last writeback data
    } fwd_sel_e;

    // Which older stages hold a writer of a given source register
    typedef struct packed {
        logic ex;
        logic mem;
        logic wb;
    } stage_hit_t;

endpackage

// File: rtl/hzd_src_match.sv
`timescale 1ns/1ps
// Compares one decode source index against the three older destinations.
// Assumes: index 0 is the hard-wired zero register and is never a dependency;
// a stage only counts as a writer when its write-enable is high.
module hzd_src_match #(
    parameter int AW = 5
) (
    input  logic [AW-1:0]      src_idx,
    input  logic               src_use,
    input  logic [AW-1:0]      ex_dst,
    input  logic               ex_wr,
    input  logic [AW-1:0]      mem_dst,
    input  logic               mem_wr,
    input  logic [AW-1:0]      wb_dst,
    input  logic               wb_wr,
    output hzd_pkg::stage_hit_t hit
);

    logic src_live;

    // A source participates only if it is read and is not the zero register
    always_comb src_live = src_use && (src_idx != '0);

    // Per-stage equality against enabled writers
    always_comb begin
        hit.ex  = src_live && ex_wr  && (ex_dst  == src_idx);
        hit.mem = src_live && mem_wr && (mem_dst == src_idx);
        hit.wb  = src_live && wb_wr  && (wb_dst  == src_idx);
    end

endmodule

// File: rtl/hzd_src_policy.sv
`timescale 1ns/1ps
// Turns the stage hits of one operand into a stall request and a select.
// Assumes: BYPASS=0 means no forwarding network; WB_SAME_CYCLE=1 means the
// register file returns a value written in the same cycle to a decode read.
module hzd_src_policy #(
    parameter bit BYPASS        = 1'b1,
    parameter bit WB_SAME_CYCLE = 1'b1
) (
    input  hzd_pkg::stage_hit_t hit,
    input  logic                ex_ld,
    output logic                need_stall,
    output logic [1:0]          sel_next
);

    import hzd_pkg::*;

    logic wb_blocks;
    logic interlock_stall;
    logic load_use_stall;
    logic [1:0] bypass_sel;

    // A writeback match needs action only if decode cannot see that write
    always_comb wb_blocks = hit.wb && !WB_SAME_CYCLE;

    // Interlock-only: wait until the producer has left every stage still ahead
    always_comb interlock_stall = hit.ex || hit.mem || wb_blocks;

    // Bypass: only a load in execute cannot feed the next cycle
    always_comb load_use_stall = hit.ex && ex_ld;

    // Youngest producer wins: execute, then memory, then writeback
    always_comb begin
        if (hit.ex)
            bypass_sel = FWD_EXM;
        else if (hit.mem)
            bypass_sel = FWD_MWB;
        else if (wb_blocks)
            bypass_sel = FWD_WBH;
        else
            bypass_sel = FWD_RF;
    end

    // Pick the variant fixed by the mode parameter
    generate
        if (BYPASS) begin : g_bypass
            always_comb need_stall = load_use_stall;
            always_comb sel_next   = bypass_sel;
        end else begin : g_interlock
            logic unused_bypass;
            always_comb unused_bypass = load_use_stall ^ (^bypass_sel);
            always_comb need_stall = interlock_stall;
            always_comb sel_next   = FWD_RF;
        end
    endgenerate

endmodule

// File: rtl/hzd_sel_reg.sv
`timescale 1ns/1ps
// Registers the operand selects into the decode/execute boundary.
// Assumes: a stall sends a bubble into execute, which reads nothing, so its
// selects are cleared; synchronous active-low reset.
module hzd_sel_reg #(
    parameter int NSRC = 2,
    localparam int SW  = 2 * NSRC
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stall,
    input  logic [SW-1:0] sel_next,
    output logic [SW-1:0] sel_q
);

    // Capture next-cycle selects, or clear them for a bubble or reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (stall)
            sel_q <= '0;
        else
            sel_q <= sel_next;
    end

endmodule

// File: rtl/hazard_resolver.sv
`timescale 1ns/1ps
// Decode-stage hazard resolver for a five-stage integer pipeline.
// Compares every decode source with the execute, memory and writeback
// destinations, raises stall/bubble when a value cannot reach execute in time,
// and otherwise produces registered operand selects used in execute.
// Assumes: caller freezes PC and fetch/decode on stall_o and loads a bubble
// into decode/execute on bubble_o.
module hazard_resolver #(
    parameter int AW            = 5,
    parameter int NSRC          = 2,
    parameter bit BYPASS        = 1'b1,
    parameter bit WB_SAME_CYCLE = 1'b1,
    localparam int SW           = 2 * NSRC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NSRC*AW-1:0] dec_src_idx,
    input  logic [NSRC-1:0]    dec_src_use,
    input  logic [AW-1:0]      ex_dst,
    input  logic               ex_wr,
    input  logic               ex_ld,
    input  logic [AW-1:0]      mem_dst,
    input  logic               mem_wr,
    input  logic [AW-1:0]      wb_dst,
    input  logic               wb_wr,
    output logic               stall_o,
    output logic               bubble_o,
    output logic [SW-1:0]      fwd_sel_o
);

    import hzd_pkg::*;

    stage_hit_t        hits   [NSRC];
    logic [NSRC-1:0]   src_stall;
    logic [SW-1:0]     sel_next;
    logic              stall_any;

    // One matcher and one policy per source operand
    generate
        for (genvar k = 0; k < NSRC; k++) begin : g_src
            hzd_src_match #(.AW(AW)) u_match (
                .src_idx (dec_src_idx[k*AW +: AW]),
                .src_use (dec_src_use[k]),
                .ex_dst  (ex_dst),
                .ex_wr   (ex_wr),
                .mem_dst (mem_dst),
                .mem_wr  (mem_wr),
                .wb_dst  (wb_dst),
                .wb_wr   (wb_wr),
                .hit     (hits[k])
            );

            hzd_src_policy #(
                .BYPASS        (BYPASS),
                .WB_SAME_CYCLE (WB_SAME_CYCLE)
            ) u_policy (
                .hit        (hits[k]),
                .ex_ld      (ex_ld),
                .need_stall (src_stall[k]),
                .sel_next   (sel_next[2*k +: 2])
            );
        end
    endgenerate

    // Any blocked operand holds the whole decode instruction
    always_comb stall_any = |src_stall;

    // Freeze front end and feed a bubble into execute on the same condition
    always_comb begin
        stall_o  = stall_any;
        bubble_o = stall_any;
    end

    hzd_sel_reg #(.NSRC(NSRC)) u_sel_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .stall    (stall_any),
        .sel_next (sel_next),
        .sel_q    (fwd_sel_o)
    );

endmodule

// File: rtl/hazard_resolver_chk.sv
`timescale 1ns/1ps
// Property checker for hazard_resolver, attached by bind below.
module hazard_resolver_chk #(
    parameter int AW            = 5,
    parameter int NSRC          = 2,
    parameter bit BYPASS        = 1'b1,
    parameter bit WB_SAME_CYCLE = 1'b1,
    localparam int SW           = 2 * NSRC
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NSRC*AW-1:0] dec_src_idx,
    input logic [NSRC-1:0]    dec_src_use,
    input logic [AW-1:0]      ex_dst,
    input logic               ex_wr,
    input logic               ex_ld,
    input logic [AW-1:0]      mem_dst,
    input logic               mem_wr,
    input logic [AW-1:0]      wb_dst,
    input logic               wb_wr,
    input logic               stall_o,
    input logic               bubble_o,
    input logic [SW-1:0]      fwd_sel_o
);

    // R1
    zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_src_idx == '0) |-> !stall_o);

    // R2
    unused_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_src_use == '0) |-> !stall_o);

    // R10
    bubble_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_o |=> (fwd_sel_o == '0));

    // R12
    no_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_wr && !mem_wr && !wb_wr) |-> !stall_o);

    generate
        if (BYPASS) begin : g_byp
            // R5
            ex_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!stall_o && dec_src_use[0] && dec_src_idx[AW-1:0] != '0 &&
                 ex_wr && !ex_ld && ex_dst == dec_src_idx[AW-1:0])
                |=> (fwd_sel_o[1:0] == 2'd1));
            // R6
            load_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (dec_src_use[0] && dec_src_idx[AW-1:0] != '0 &&
                 ex_wr && ex_ld && ex_dst == dec_src_idx[AW-1:0]) |-> stall_o);
            if (WB_SAME_CYCLE) begin : g_same
                // R8
                no_hold_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    fwd_sel_o[1:0] != 2'd3);
            end
        end else begin : g_il
            // R13
            il_sel_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                fwd_sel_o == '0);
            // R3
            il_ex_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (dec_src_use[0] && dec_src_idx[AW-1:0] != '0 &&
                 ex_wr && ex_dst == dec_src_idx[AW-1:0]) |-> stall_o);
        end
    endgenerate

endmodule

bind hazard_resolver hazard_resolver_chk #(
    .AW            (AW),
    .NSRC          (NSRC),
    .BYPASS        (BYPASS),
    .WB_SAME_CYCLE (WB_SAME_CYCLE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dec_src_idx (dec_src_idx),
    .dec_src_use (dec_src_use),
    .ex_dst      (ex_dst),
    .ex_wr       (ex_wr),
    .ex_ld       (ex_ld),
    .mem_dst     (mem_dst),
    .mem_wr      (mem_wr),
    .wb_dst      (wb_dst),
    .wb_wr       (wb_wr),
    .stall_o     (stall_o),
    .bubble_o    (bubble_o),
    .fwd_sel_o   (fwd_sel_o)
);

// File: tb/hazard_resolver_bench.sv
`timescale 1ns/1ps
// Runs one stimulus stream through all four mode combinations and compares
// each against a model computed in the bench.
module hazard_resolver_bench;

    localparam int AW   = 5;
    localparam int NSRC = 2;
    localparam int NCFG = 4;   // cfg g: BYPASS = g[1], WB_SAME_CYCLE = g[0]

    logic               clk = 1'b0;
    logic               rst_n;
    logic [NSRC*AW-1:0] dec_src_idx;
    logic [NSRC-1:0]    dec_src_use;
    logic [AW-1:0]      ex_dst, mem_dst, wb_dst;
    logic               ex_wr, ex_ld, mem_wr, wb_wr;

    logic               st  [NCFG];
    logic               bb  [NCFG];
    logic [2*NSRC-1:0]  fs  [NCFG];
    logic [2*NSRC-1:0]  exp_fs [NCFG];

    int    n_chk  = 0;
    int    n_fail = 0;
    string cur_tag = "";

    always #2 clk = ~clk;   // 250 MHz

    generate
        for (genvar g = 0; g < NCFG; g++) begin : g_cfg
            hazard_resolver #(
                .AW(AW), .NSRC(NSRC),
                .BYPASS(g[1]), .WB_SAME_CYCLE(g[0])
            ) u_hazard_resolver (
                .clk(clk), .rst_n(rst_n),
                .dec_src_idx(dec_src_idx), .dec_src_use(dec_src_use),
                .ex_dst(ex_dst), .ex_wr(ex_wr), .ex_ld(ex_ld),
                .mem_dst(mem_dst), .mem_wr(mem_wr),
                .wb_dst(wb_dst), .wb_wr(wb_wr),
                .stall_o(st[g]), .bubble_o(bb[g]), .fwd_sel_o(fs[g])
            );
        end
    endgenerate

    // Stage hits {ex, mem, wb} for operand op
    function automatic logic [2:0] m_hits(int op);
        logic [AW-1:0] s;
        logic live;
        s = dec_src_idx[op*AW +: AW];
        live = dec_src_use[op] && (s != 0);
        return {live && ex_wr && ex_dst == s,
                live && mem_wr && mem_dst == s,
                live && wb_wr && wb_dst == s};
    endfunction

    function automatic logic m_stall(int cfg);
        logic r = 1'b0;
        for (int op = 0; op < NSRC; op++) begin
            logic [2:0] h = m_hits(op);
            if (cfg[1]) r |= h[2] && ex_ld;                       // R6
            else        r |= h[2] || h[1] || (h[0] && !cfg[0]);   // R3 R4
        end
        return r;
    endfunction

    function automatic logic [1:0] m_sel(int cfg, int op);
        logic [2:0] h = m_hits(op);
        if (!cfg[1]) return 2'd0;                   // R13
        if (h[2]) return 2'd1;                      // R5 R9
        if (h[1]) return 2'd2;                      // R7
        if (h[0]) return cfg[0] ? 2'd0 : 2'd3;      // R8
        return 2'd0;
    endfunction

    task automatic chk(string dflt, string what, int cfg, logic [31:0] act, logic [31:0] expv);
        string tag = (cur_tag != "") ? cur_tag : dflt;
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s cfg%0d %s actual=%0h expected=%0h", tag, cfg, what, act, expv);
        end
    endtask

    // Check combinational outputs now, registered selects one edge later
    task automatic run_cycle();
        #1;
        for (int g = 0; g < NCFG; g++) begin
            logic es = m_stall(g);
            chk(g[1] ? "R6" : "R3", "stall", g, st[g], es);
            chk("R10", "bubble", g, bb[g], es);
            for (int op = 0; op < NSRC; op++)
                exp_fs[g][2*op +: 2] = es ? 2'd0 : m_sel(g, op);
        end
        @(negedge clk);
        for (int g = 0; g < NCFG; g++)
            chk(g[1] ? "R7" : "R13", "sel", g, fs[g], exp_fs[g]);
    endtask

    task automatic set_in(logic [AW-1:0] s0, logic [AW-1:0] s1, logic [1:0] use_b,
                          logic [AW-1:0] xd, logic xw, logic xl,
                          logic [AW-1:0] md, logic mw,
                          logic [AW-1:0] wd, logic ww);
        dec_src_idx = {s1, s0};
        dec_src_use = use_b;
        ex_dst = xd;  ex_wr = xw;  ex_ld = xl;
        mem_dst = md; mem_wr = mw;
        wb_dst = wd;  wb_wr = ww;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_0c11));
        rst_n = 1'b0;
        set_in(5'd3, 5'd3, 2'b11, 5'd3, 1'b1, 1'b0, 5'd3, 1'b1, 5'd3, 1'b1);
        repeat (3) @(negedge clk);
        for (int g = 0; g < NCFG; g++) begin
            cur_tag = "R11";
            chk("R11", "reset sel", g, fs[g], 0);
        end
        cur_tag = "";
        rst_n = 1'b1;

        // R1: zero register on both sources, all stages writing x0
        cur_tag = "R1";
        set_in(5'd0, 5'd0, 2'b11, 5'd0, 1'b1, 1'b1, 5'd0, 1'b1, 5'd0, 1'b1);
        run_cycle();
        // R2: matches present but sources unused
        cur_tag = "R2";
        set_in(5'd4, 5'd4, 2'b00, 5'd4, 1'b1, 1'b1, 5'd4, 1'b1, 5'd4, 1'b1);
        run_cycle();
        // R12: matching destinations with write-enables low
        cur_tag = "R12";
        set_in(5'd6, 5'd6, 2'b11, 5'd6, 1'b0, 1'b1, 5'd6, 1'b0, 5'd6, 1'b0);
        run_cycle();
        // R5: ALU producer in execute
        cur_tag = "R5";
        set_in(5'd7, 5'd1, 2'b11, 5'd7, 1'b1, 1'b0, 5'd9, 1'b1, 5'd9, 1'b1);
        run_cycle();
        // R6: load producer in execute
        cur_tag = "R6";
        set_in(5'd7, 5'd1, 2'b11, 5'd7, 1'b1, 1'b1, 5'd9, 1'b1, 5'd9, 1'b1);
        run_cycle();
        // R7: producer in memory, on operand 1
        cur_tag = "R7";
        set_in(5'd2, 5'd8, 2'b11, 5'd9, 1'b1, 1'b0, 5'd8, 1'b1, 5'd9, 1'b1);
        run_cycle();
        // R8 and R4: producer only in writeback
        cur_tag = "R8";
        set_in(5'd10, 5'd10, 2'b11, 5'd9, 1'b1, 1'b0, 5'd9, 1'b1, 5'd10, 1'b1);
        run_cycle();
        // R9: every stage writes the same register; then memory and writeback
        cur_tag = "R9";
        set_in(5'd11, 5'd0, 2'b01, 5'd11, 1'b1, 1'b0, 5'd11, 1'b1, 5'd11, 1'b1);
        run_cycle();
        set_in(5'd11, 5'd0, 2'b01, 5'd11, 1'b0, 1'b0, 5'd11, 1'b1, 5'd11, 1'b1);
        run_cycle();
        // R4: dependent right behind producer, walked through the stages
        cur_tag = "R4";
        set_in(5'd12, 5'd0, 2'b01, 5'd12, 1'b1, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0);
        run_cycle();
        set_in(5'd12, 5'd0, 2'b01, 5'd0, 1'b0, 1'b0, 5'd12, 1'b1, 5'd0, 1'b0);
        run_cycle();
        set_in(5'd12, 5'd0, 2'b01, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd12, 1'b1);
        run_cycle();

        // Random traffic on a narrow index range to force frequent matches
        cur_tag = "";
        for (int i = 0; i < 3000; i++) begin
            set_in(5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
                   2'($urandom_range(0, 3)),
                   5'($urandom_range(0, 3)), 1'($urandom), 1'($urandom),
                   5'($urandom_range(0, 3)), 1'($urandom),
                   5'($urandom_range(0, 3)), 1'($urandom));
            if (i % 97 == 5) rst_n = 1'b0; else rst_n = 1'b1;
            if (!rst_n) begin
                @(negedge clk);
                for (int g = 0; g < NCFG; g++) chk("R11", "reset sel", g, fs[g], 0);
            end else begin
                run_cycle();
            end
        end
        finish_run();
    end

endmodule